// File: doc/BRIEF.md
# DMA Channel Configuration Guard

This block sits beside one DMA channel. It watches the register writes aimed at that channel and decides whether the channel may be started. It keeps its own copy of the fields that matter: source and destination addresses, access widths, transfer count, lock control, the two master endian bits and the default link-list enable. From these it checks three things. Each address must be aligned to its access width. The transfer count must suit the ratio between the destination width and the source width. No prohibited endian or lock setting may be present. It also catches an unsafe order of writes: a rewrite of the channel configuration while the channel is busy and the link-list default is still enabled.

Each cause of error is latched in its own sticky bit, and these bits are presented as a status word. Writing ones clears them. Every check is re-evaluated on the registered field copies, so the start permit follows a register write by one cycle. A start request is granted only while the permit is high; a refused request latches its own flag. The block also decodes, for each address, which of two bus master ports it should use. Addresses inside a parameterised internal peripheral window go to the second port, and all others go to the first.

Top module: `dma_cfg_guard`

## Requirements
- R1: Source width codes are 0 byte, 1 halfword, 2 word and 3 reserved. A halfword source with source address bit 0 set, a word source with either of source address bits 1:0 set, or a reserved code sets error bit 0.
- R2: The same rule applies to the destination address and destination width, and sets error bit 1.
- R3: Error bit 2 is set when the count does not fit the width ratio. That is a byte source with halfword destination and an odd count, a byte source with word destination and a count that is not a multiple of four, or a halfword source with word destination and an odd count. A destination narrower than or equal to the source imposes no count rule.
- R4: A one in either endian bit (configuration register bits 0 and 1, one meaning big endian) sets error bit 3.
- R5: A one in the lock control (transfer register bit 16) sets error bit 4.
- R6: Error bit 5 is set when the configuration register (address 3) is written while chanBusy is high and the link-list enable (address 4, bit 0) already holds one. With the enable cleared beforehand, the same write sets no flag.
- R7: srcPortSel and dstPortSel are 1 when (address & PERIPH_MASK) == PERIPH_BASE, selecting the second master port, and 0 otherwise.
- R8: Error bits are sticky. Writing address 5 clears the bits whose data bits are one, but a cause that is still present sets its bit again in the same cycle.
- R9: startPermit is registered. It is high one cycle after a write only if no configuration check fails and error bit 5 is clear. startGrant is startReq while startPermit is high. A startReq seen while startPermit is low sets error bit 6.
- R10: After reset, all error bits are 0. Once the first clock after reset has passed, startPermit is 1, because the zeroed fields pass every check.

Register addresses: 0 source address, 1 destination address, 2 transfer register (count in bits 11:0, source width in 13:12, destination width in 15:14, lock in 16), 3 configuration, 4 link-list enable, 5 error clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register address |
| wrData | input | 32 | Write data |
| chanBusy | input | 1 | Channel transfer in progress |
| startReq | input | 1 | Request to start the channel |
| startPermit | output | 1 | All checks pass |
| startGrant | output | 1 | Start request accepted |
| errFlags | output | 7 | Sticky error status word |
| srcPortSel | output | 1 | Master port for source address (1 = second) |
| dstPortSel | output | 1 | Master port for destination address (1 = second) |

## Verification
The hardest case to reach is the write-ordering rule. It depends on the history of two registers and on the busy input at the moment of the write, not on any field's current value. The stimulus sets the link-list enable, raises chanBusy and then rewrites the configuration, which must latch the flag. It then clears the enable, clears the flag and repeats the rewrite while still busy, which must leave the flag clear. A second hard case is set-over-clear on a sticky bit. The stimulus clears a flag while its cause is still programmed, and only then removes the cause.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  typedef enum logic [1:0] {
    WID_BYTE = 2'd0,
    WID_HALF = 2'd1,
    WID_WORD = 2'd2,
    WID_RSVD = 2'd3
  } width_e;

  localparam int CHK_N    = 5;
  localparam int FLAG_N   = 7;
  localparam int F_SRC    = 0;
  localparam int F_DST    = 1;
  localparam int F_COUNT  = 2;
  localparam int F_ENDIAN = 3;
  localparam int F_LOCK   = 4;
  localparam int F_ORDER  = 5;
  localparam int F_REFUSE = 6;

  localparam logic [2:0] A_SRC  = 3'd0;
  localparam logic [2:0] A_DST  = 3'd1;
  localparam logic [2:0] A_XFER = 3'd2;
  localparam logic [2:0] A_CFG  = 3'd3;
  localparam logic [2:0] A_LINK = 3'd4;
  localparam logic [2:0] A_CLR  = 3'd5;

  typedef struct packed {
    logic ldSrc;
    logic ldDst;
    logic ldXfer;
    logic ldCfg;
    logic ldLink;
    logic clrFlags;
  } strobe_t;
endpackage

// File: rtl/dma_cfg_datapath.sv
module dma_cfg_datapath
  import dma_cfg_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          CNT_W       = 12,
  parameter logic [31:0] PERIPH_BASE = 32'h4000_0000,
  parameter logic [31:0] PERIPH_MASK = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] wrData,
  output logic [CHK_N-1:0]  chk,
  output logic              linkEn,
  output logic              srcPortSel,
  output logic              dstPortSel
);
  localparam int SW_LO = CNT_W;
  localparam int DW_LO = CNT_W + 2;
  localparam int LOCK_BIT = CNT_W + 4;

  logic [ADDR_W-1:0] srcAddrQ, dstAddrQ;
  logic [CNT_W-1:0]  cntQ;
  width_e            srcWQ, dstWQ;
  logic              lockQ, linkQ;
  logic [1:0]        endianQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcAddrQ <= '0;
      dstAddrQ <= '0;
      cntQ     <= '0;
      srcWQ    <= WID_BYTE;
      dstWQ    <= WID_BYTE;
      lockQ    <= 1'b0;
      endianQ  <= 2'b00;
      linkQ    <= 1'b0;
    end else begin
      if (strb.ldSrc) srcAddrQ <= wrData;
      if (strb.ldDst) dstAddrQ <= wrData;
      if (strb.ldXfer) begin
        cntQ  <= wrData[CNT_W-1:0];
        srcWQ <= width_e'(wrData[SW_LO+1:SW_LO]);
        dstWQ <= width_e'(wrData[DW_LO+1:DW_LO]);
        lockQ <= wrData[LOCK_BIT];
      end
      if (strb.ldCfg)  endianQ <= wrData[1:0];
      if (strb.ldLink) linkQ   <= wrData[0];
    end
  end

  function automatic logic misaligned(width_e w, logic [1:0] lowBits);
    case (w)
      WID_HALF: misaligned = lowBits[0];
      WID_WORD: misaligned = |lowBits;
      WID_RSVD: misaligned = 1'b1;
      default:  misaligned = 1'b0;
    endcase
  endfunction

  function automatic logic [1:0] effWidth(width_e w);
    effWidth = (w == WID_RSVD) ? 2'd2 : 2'(w);
  endfunction

  logic [1:0] sEff, dEff, ratio;
  logic       countBad;

  always_comb begin
    sEff  = effWidth(srcWQ);
    dEff  = effWidth(dstWQ);
    ratio = (dEff > sEff) ? (dEff - sEff) : 2'd0;
    case (ratio)
      2'd1:    countBad = cntQ[0];
      2'd2:    countBad = |cntQ[1:0];
      default: countBad = 1'b0;
    endcase
  end

  assign chk[F_SRC]    = misaligned(srcWQ, srcAddrQ[1:0]);
  assign chk[F_DST]    = misaligned(dstWQ, dstAddrQ[1:0]);
  assign chk[F_COUNT]  = countBad;
  assign chk[F_ENDIAN] = |endianQ;
  assign chk[F_LOCK]   = lockQ;
  assign linkEn        = linkQ;

  assign srcPortSel = ((srcAddrQ & PERIPH_MASK[ADDR_W-1:0]) == PERIPH_BASE[ADDR_W-1:0]);
  assign dstPortSel = ((dstAddrQ & PERIPH_MASK[ADDR_W-1:0]) == PERIPH_BASE[ADDR_W-1:0]);

  AST_LINK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldLink |=> $stable(linkQ)) else $error("link enable moved without write"); // R6
  AST_LOCK_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ldXfer |=> $stable(chk[F_LOCK])) else $error("lock check moved without write"); // R5
endmodule

// File: rtl/dma_cfg_ctrl.sv
module dma_cfg_ctrl
  import dma_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [FLAG_N-1:0] clrMask,
  input  logic              chanBusy,
  input  logic              startReq,
  input  logic [CHK_N-1:0]  chk,
  input  logic              linkEn,
  output strobe_t           strb,
  output logic [FLAG_N-1:0] flags,
  output logic              startPermit,
  output logic              startGrant
);
  logic [FLAG_N-1:0] flagsQ, setVec, clrVec;
  logic              permitQ, orderHit;

  always_comb begin
    strb.ldSrc    = wrEn && (wrAddr == A_SRC);
    strb.ldDst    = wrEn && (wrAddr == A_DST);
    strb.ldXfer   = wrEn && (wrAddr == A_XFER);
    strb.ldCfg    = wrEn && (wrAddr == A_CFG);
    strb.ldLink   = wrEn && (wrAddr == A_LINK);
    strb.clrFlags = wrEn && (wrAddr == A_CLR);
  end

  assign orderHit = strb.ldCfg && chanBusy && linkEn;

  always_comb begin
    setVec               = '0;
    setVec[CHK_N-1:0]    = chk;
    setVec[F_ORDER]      = orderHit;
    setVec[F_REFUSE]     = startReq && !permitQ;
    clrVec               = strb.clrFlags ? clrMask : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ  <= '0;
      permitQ <= 1'b0;
    end else begin
      flagsQ  <= setVec | (flagsQ & ~clrVec);
      permitQ <= (chk == '0) && !(orderHit || (flagsQ[F_ORDER] && !clrVec[F_ORDER]));
    end
  end

  assign flags       = flagsQ;
  assign startPermit = permitQ;
  assign startGrant  = startReq && permitQ;

  AST_REFUSE_FLAGGED: assert property (@(posedge clk) disable iff (!rstN)
    startReq && !startPermit |=> flags[F_REFUSE]) else $error("refusal not latched"); // R9
  AST_ORDER_CAUGHT: assert property (@(posedge clk) disable iff (!rstN)
    strb.ldCfg && chanBusy && linkEn |=> flags[F_ORDER] && !startPermit) else $error("ordering miss"); // R6
  AST_PERMIT_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    startPermit |-> ($past(chk) == '0)) else $error("permit with failing check"); // R9
  AST_GRANT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    startGrant |-> startPermit) else $error("grant without permit"); // R9

  for (genvar i = 0; i < FLAG_N; i++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flags[i]) |-> $past(strb.clrFlags && clrMask[i])) else $error("flag dropped"); // R8
  end
endmodule

// File: rtl/dma_cfg_guard.sv
module dma_cfg_guard
  import dma_cfg_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter int          CNT_W       = 12,
  parameter logic [31:0] PERIPH_BASE = 32'h4000_0000,
  parameter logic [31:0] PERIPH_MASK = 32'hF000_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        wrAddr,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              chanBusy,
  input  logic              startReq,
  output logic              startPermit,
  output logic              startGrant,
  output logic [FLAG_N-1:0] errFlags,
  output logic              srcPortSel,
  output logic              dstPortSel
);
  strobe_t          strb;
  logic [CHK_N-1:0] chk;
  logic             linkEn;

  dma_cfg_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .PERIPH_BASE(PERIPH_BASE), .PERIPH_MASK(PERIPH_MASK)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData),
    .chk(chk), .linkEn(linkEn), .srcPortSel(srcPortSel), .dstPortSel(dstPortSel)
  );

  dma_cfg_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr),
    .clrMask(wrData[FLAG_N-1:0]), .chanBusy(chanBusy), .startReq(startReq),
    .chk(chk), .linkEn(linkEn), .strb(strb), .flags(errFlags),
    .startPermit(startPermit), .startGrant(startGrant)
  );
endmodule

// File: tb/test_dma_cfg_guard.sv
module test_dma_cfg_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        chanBusy = 1'b0;
  logic        startReq = 1'b0;
  logic        startPermit, startGrant, srcPortSel, dstPortSel;
  logic [6:0]  errFlags;
  int          nChecks = 0;
  int          nFails = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  dma_cfg_guard i_dma_cfg_guard (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .chanBusy(chanBusy), .startReq(startReq), .startPermit(startPermit),
    .startGrant(startGrant), .errFlags(errFlags),
    .srcPortSel(srcPortSel), .dstPortSel(dstPortSel)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] xf(int cnt, int sw, int dw, bit lock);
    xf = {15'd0, lock, 2'(dw), 2'(sw), 12'(cnt)};
  endfunction

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic goodCfg();
    chanBusy = 1'b0;
    wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd2, xf(4, 0, 0, 0));
    wr(3'd3, 32'h0); wr(3'd4, 32'h0); wr(3'd5, 32'h7F);
    settle();
  endtask

  task automatic t_reset();
    check("R10 flags", 32'(errFlags), 32'h0);
    check("R10 permit", 32'(startPermit), 32'h1);
  endtask

  task automatic t_srcAlign();
    goodCfg();
    wr(3'd0, 32'h11); wr(3'd2, xf(4, 1, 0, 0)); settle();
    check("R1 half odd", 32'(errFlags[0]), 32'h1);
    check("R1 permit low", 32'(startPermit), 32'h0);
    goodCfg();
    wr(3'd0, 32'h12); wr(3'd2, xf(4, 2, 0, 0)); settle();
    check("R1 word off2", 32'(errFlags[0]), 32'h1);
    goodCfg();
    wr(3'd0, 32'h14); wr(3'd2, xf(4, 2, 2, 0)); settle();
    check("R1 word aligned", 32'(errFlags), 32'h0);
    check("R1 permit high", 32'(startPermit), 32'h1);
  endtask

  task automatic t_dstAlign();
    goodCfg();
    wr(3'd1, 32'h6); wr(3'd2, xf(4, 0, 2, 0)); settle();
    check("R2 word off2", 32'(errFlags[1:0]), 32'h2);
    goodCfg();
    wr(3'd2, xf(4, 0, 3, 0)); settle();
    check("R2 reserved width", 32'(errFlags[1]), 32'h1);
  endtask

  task automatic t_count();
    goodCfg();
    wr(3'd2, xf(6, 0, 2, 0)); settle();
    check("R3 byte-word 6", 32'(errFlags[2]), 32'h1);
    goodCfg();
    wr(3'd2, xf(8, 0, 2, 0)); settle();
    check("R3 byte-word 8", 32'(errFlags), 32'h0);
    goodCfg();
    wr(3'd2, xf(3, 1, 2, 0)); settle();
    check("R3 half-word 3", 32'(errFlags[2]), 32'h1);
    goodCfg();
    wr(3'd2, xf(3, 0, 1, 0)); settle();
    check("R3 byte-half 3", 32'(errFlags[2]), 32'h1);
    goodCfg();
    wr(3'd2, xf(3, 2, 0, 0)); settle();
    check("R3 narrowing free", 32'(errFlags), 32'h0);
  endtask

  task automatic t_endianLock();
    goodCfg();
    wr(3'd3, 32'h2); settle();
    check("R4 endian", 32'(errFlags), 32'h8);
    goodCfg();
    wr(3'd2, xf(4, 0, 0, 1)); settle();
    check("R5 lock", 32'(errFlags), 32'h10);
    check("R5 permit low", 32'(startPermit), 32'h0);
  endtask

  task automatic t_order();
    goodCfg();
    wr(3'd4, 32'h1);
    chanBusy = 1'b1;
    wr(3'd3, 32'h0); settle();
    check("R6 violation", 32'(errFlags[5]), 32'h1);
    check("R6 permit low", 32'(startPermit), 32'h0);
    wr(3'd4, 32'h0); wr(3'd5, 32'h20);
    wr(3'd3, 32'h0); settle();
    check("R6 safe order", 32'(errFlags[5]), 32'h0);
    check("R6 permit back", 32'(startPermit), 32'h1);
    chanBusy = 1'b0;
  endtask

  task automatic t_port();
    goodCfg();
    wr(3'd0, 32'h4000_1000); wr(3'd1, 32'h2000_0000); settle();
    check("R7 src port", 32'(srcPortSel), 32'h1);
    check("R7 dst port", 32'(dstPortSel), 32'h0);
  endtask

  task automatic t_sticky();
    goodCfg();
    wr(3'd3, 32'h1); settle();
    wr(3'd5, 32'h8); settle();
    check("R8 set over clear", 32'(errFlags[3]), 32'h1);
    wr(3'd3, 32'h0); settle();
    check("R8 stays after fix", 32'(errFlags[3]), 32'h1);
    wr(3'd5, 32'h8); settle();
    check("R8 cleared", 32'(errFlags[3]), 32'h0);
  endtask

  task automatic t_start();
    goodCfg();
    @(negedge clk); startReq = 1'b1; #1;
    check("R9 grant", 32'(startGrant), 32'h1);
    @(negedge clk); startReq = 1'b0;
    check("R9 no refuse", 32'(errFlags[6]), 32'h0);
    wr(3'd0, 32'h1); wr(3'd2, xf(4, 1, 0, 0));
    check("R9 permit lag", 32'(startPermit), 32'h1);
    settle();
    check("R9 permit drop", 32'(startPermit), 32'h0);
    startReq = 1'b1; #1;
    check("R9 no grant", 32'(startGrant), 32'h0);
    @(negedge clk); startReq = 1'b0;
    check("R9 refused", 32'(errFlags[6]), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_srcAlign();
    t_dstAlign();
    t_count();
    t_endianLock();
    t_order();
    t_port();
    t_sticky();
    t_start();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule